// File: doc/BRIEF.md
# PCIe Root-Port Power-Up Sequencer

This block is a hardware state machine that brings a PCIe root port out of power-off in a fixed order. It drives the core power-on reset (active low), the endpoint fundamental reset PERST# (active low), the slot power enable, an auxiliary clock gate, the auxiliary reset, and a hold-reset for the link training state machine (LTSSM). It then writes a configuration word into every lane of every PHY through a request/acknowledge port. After that it selects root-complex mode, enables link training and raises a done flag.

All waits are counted in pulses of a single timebase input `tick_i`, so a system clock of any frequency can be used and a testbench can shorten the delays. A PHY handshake that is not acknowledged in time stops the sequence and raises an error flag. When that happens every control output keeps its current value. A combinational link-status decode of the controller's debug word is also provided.

Top module: `pcie_rp_pwrseq`

## Requirements
- R1: Out of reset the outputs are as follows. `core_por_n_o`=1, `perst_n_o`=1, `slot_pwr_en_o`=0, `aux_clk_en_o`=0, `aux_rst_o`=1, `ltssm_hold_o`=0, `phy_cr_sel_o`=0, `phy_req_o`=0, `dev_type_o`=0, `ltssm_en_o`=0, `done_o`=0, `err_o`=0.
- R2: A `start_i` pulse in idle drives `core_por_n_o` low on that edge. `perst_n_o` goes low one cycle later, and `slot_pwr_en_o` goes high one cycle after that. Only one control output changes per cycle.
- R3: `perst_n_o` stays low for exactly HOLD_TICKS timebase ticks after slot power is enabled, then rises. `core_por_n_o` rises one cycle later. PERST# is never low while the core power-on reset is released.
- R4: After the core reset is released, the following changes occur on consecutive cycles: `aux_clk_en_o` rises, `ltssm_hold_o` rises, `aux_rst_o` falls, and every bit of `phy_cr_sel_o` is set.
- R5: The first lane write request starts only after SETTLE_TICKS ticks have elapsed since the PHY select was set.
- R6: NUM_PHY×LANES_PER_PHY lane writes are issued in PHY-major order, with lane index ascending within each PHY. Each write carries `phy_idx_o` equal to the PHY index, `phy_addr_o` = 0x1008 + 0x100×lane, and `phy_wdata_o` = 0xE21. In that data word, bit 0 is CDR tracking, bit 5 is the loss-of-signal threshold, bit 9 is termination enable, bit 10 is AC/DC termination and bit 11 is lane enable. Writes occur only while the LTSSM is held, the auxiliary clock runs and the auxiliary reset is released.
- R7: Each write raises `phy_req_o` and holds it until `phy_ack_i` is 1. It then drops the request and waits for the acknowledge to return to 0. A new request never starts while the acknowledge is still high.
- R8: After the last write, the following changes occur on consecutive cycles: `aux_clk_en_o` falls, `ltssm_hold_o` falls, `aux_clk_en_o` rises again, `dev_type_o` becomes 4 (root complex), `ltssm_en_o` rises, and `done_o` rises.
- R9: If either phase of a handshake lasts ACK_TICKS ticks without the expected acknowledge level, `err_o` rises. All other outputs, including `phy_req_o`, then keep their values, and `done_o` never rises.
- R10: `link_up_o` is 1 exactly when bit 4 of `link_dbg_i` is 1 and bit 29 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin the bring-up sequence (accepted in idle) |
| tick_i | input | 1 | Timebase pulse; all delays count these |
| phy_ack_i | input | 1 | Acknowledge from the PHY control-register port |
| link_dbg_i | input | 32 | Controller link debug status word |
| core_por_n_o | output | 1 | Core power-on reset, active low |
| perst_n_o | output | 1 | Endpoint fundamental reset, active low |
| slot_pwr_en_o | output | 1 | Slot power enable |
| aux_clk_en_o | output | 1 | Auxiliary clock gate enable |
| aux_rst_o | output | 1 | Auxiliary reset, active high |
| ltssm_hold_o | output | 1 | Holds link training in reset |
| phy_cr_sel_o | output | NUM_PHY | Per-PHY control-register interface select |
| phy_req_o | output | 1 | Lane write request |
| phy_idx_o | output | PHY_W | PHY targeted by the current write |
| phy_addr_o | output | 16 | Lane register address |
| phy_wdata_o | output | 16 | Lane configuration word |
| dev_type_o | output | 4 | Device type code; 4 selects root complex |
| ltssm_en_o | output | 1 | Link training enable |
| link_up_o | output | 1 | Decoded link-up status |
| done_o | output | 1 | Sequence completed |
| err_o | output | 1 | Handshake timeout occurred |

## Verification
Each fixed step of the sequence is due exactly one clock cycle after the previous one. The scoreboard therefore stores, for every expected control-output change, both the new output vector and the required cycle gap, and the monitor compares the cycle stamp of each observed change against that gap. The two timed waits depend on ticks rather than cycles. The bench counts the ticks it drives inside each window and compares the count with HOLD_TICKS and SETTLE_TICKS. The tick spacing is chosen so that the release edge, which comes one or two cycles after the last counted tick, cannot take in an extra tick. Lane writes are checked at each rising edge of the request against a separate queue of expected PHY, address and data values. The timeout case is checked by withholding one acknowledge and then observing that the outputs stay frozen over many cycles.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  localparam int REG_W = 16;
  localparam logic [3:0] DEV_TYPE_RC = 4'h4;

  typedef enum logic [4:0] {
    S_IDLE, S_PERST_LO, S_PWR_ON, S_HOLD, S_POR_REL, S_AUX_ON, S_LT_HOLD,
    S_AUX_REL, S_SEL, S_SETTLE, S_LANE_GO, S_LANE_WAIT, S_AUX_OFF,
    S_UNHOLD, S_AUX_ON2, S_DEVTYPE, S_LT_EN, S_DONE, S_ERR
  } seq_state_t;

  typedef enum logic [1:0] {W_IDLE, W_REQ, W_REL, W_FAIL} wr_state_t;

  // Lane register address: base plus a per-lane stride.
  function automatic logic [REG_W-1:0] lane_addr(input int lane);
    return 16'h1008 + REG_W'(lane) * 16'h0100;
  endfunction

  // Lane configuration word, assembled bit by bit.
  function automatic logic [REG_W-1:0] lane_cfg_word();
    logic [REG_W-1:0] w;
    w = '0;
    w[0]  = 1'b1; // clock/data recovery tracking
    w[5]  = 1'b1; // loss-of-signal threshold
    w[9]  = 1'b1; // termination enable
    w[10] = 1'b1; // AC/DC termination
    w[11] = 1'b1; // lane enable
    return w;
  endfunction

  // Link is up when the up bit is set and training is not in progress.
  function automatic logic link_ok(input logic [31:0] dbg);
    logic [31:0] mask;
    mask = (32'd1 << 4) | (32'd1 << 29);
    return (dbg & mask) == (32'd1 << 4);
  endfunction

endpackage

// File: rtl/tick_cnt.sv
module tick_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (tick_i && !hit_o) cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = (cnt_q >= limit_i);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && $stable(limit_i) && $past(!clr_i)) |-> (cnt_q <= limit_i)); // R3
endmodule

// File: rtl/lane_writer.sv
module lane_writer import pwrseq_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic             ack_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             req_o,
  output logic             done_o,
  output logic             err_o
);
  wr_state_t st_q;
  logic      req_q;
  logic      t_clr, t_hit;

  assign t_clr = (st_q == W_IDLE) || (st_q == W_REQ && ack_i);

  tick_cnt #(.CNT_W(CNT_W)) u_to (
    .clk(clk), .rst_n(rst_n), .clr_i(t_clr), .tick_i(tick_i),
    .limit_i(limit_i), .hit_o(t_hit)
  );

  assign done_o = (st_q == W_REL) && !ack_i;
  assign err_o  = t_hit && ((st_q == W_REQ && !ack_i) || (st_q == W_REL && ack_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= W_IDLE;
      req_q <= 1'b0;
    end else begin
      unique case (st_q)
        W_IDLE: if (go_i) begin st_q <= W_REQ; req_q <= 1'b1; end
        W_REQ: begin
          if (ack_i) begin st_q <= W_REL; req_q <= 1'b0; end
          else if (err_o) st_q <= W_FAIL;
        end
        W_REL: begin
          if (!ack_i) st_q <= W_IDLE;
          else if (err_o) st_q <= W_FAIL;
        end
        default: st_q <= W_FAIL;
      endcase
    end
  end

  assign req_o = req_q;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack_i) |=> req_o); // R7
  AST_NO_REQ_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |-> !$past(ack_i)); // R7
endmodule

// File: rtl/pcie_rp_pwrseq.sv
module pcie_rp_pwrseq import pwrseq_pkg::*; #(
  parameter int NUM_PHY       = 2,
  parameter int LANES_PER_PHY = 4,
  parameter int CNT_W         = 16,
  parameter int HOLD_TICKS    = 100,
  parameter int SETTLE_TICKS  = 1,
  parameter int ACK_TICKS     = 10,
  localparam int TOTAL_WR     = NUM_PHY * LANES_PER_PHY,
  localparam int IDX_W        = (TOTAL_WR > 1) ? $clog2(TOTAL_WR) : 1,
  localparam int PHY_W        = (NUM_PHY > 1) ? $clog2(NUM_PHY) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               tick_i,
  input  logic               phy_ack_i,
  input  logic [31:0]        link_dbg_i,
  output logic               core_por_n_o,
  output logic               perst_n_o,
  output logic               slot_pwr_en_o,
  output logic               aux_clk_en_o,
  output logic               aux_rst_o,
  output logic               ltssm_hold_o,
  output logic [NUM_PHY-1:0] phy_cr_sel_o,
  output logic               phy_req_o,
  output logic [PHY_W-1:0]   phy_idx_o,
  output logic [REG_W-1:0]   phy_addr_o,
  output logic [REG_W-1:0]   phy_wdata_o,
  output logic [3:0]         dev_type_o,
  output logic               ltssm_en_o,
  output logic               link_up_o,
  output logic               done_o,
  output logic               err_o
);
  seq_state_t       st_q;
  logic [IDX_W-1:0] idx_q;
  logic             dly_clr, dly_hit, wr_go, wr_done, wr_err, last_wr;
  logic [CNT_W-1:0] dly_lim;

  // Named internal events
  assign dly_clr = !(st_q == S_HOLD || st_q == S_SETTLE);
  assign dly_lim = (st_q == S_HOLD) ? CNT_W'(HOLD_TICKS) : CNT_W'(SETTLE_TICKS);
  assign wr_go   = (st_q == S_LANE_GO);
  assign last_wr = (idx_q == IDX_W'(TOTAL_WR - 1));

  tick_cnt #(.CNT_W(CNT_W)) u_delay (
    .clk(clk), .rst_n(rst_n), .clr_i(dly_clr), .tick_i(tick_i),
    .limit_i(dly_lim), .hit_o(dly_hit)
  );

  lane_writer #(.CNT_W(CNT_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .go_i(wr_go), .ack_i(phy_ack_i),
    .tick_i(tick_i), .limit_i(CNT_W'(ACK_TICKS)),
    .req_o(phy_req_o), .done_o(wr_done), .err_o(wr_err)
  );

  assign phy_idx_o   = PHY_W'(int'(idx_q) / LANES_PER_PHY);
  assign phy_addr_o  = lane_addr(int'(idx_q) % LANES_PER_PHY);
  assign phy_wdata_o = lane_cfg_word();
  assign link_up_o   = link_ok(link_dbg_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q          <= S_IDLE;
      idx_q         <= '0;
      core_por_n_o  <= 1'b1;
      perst_n_o     <= 1'b1;
      slot_pwr_en_o <= 1'b0;
      aux_clk_en_o  <= 1'b0;
      aux_rst_o     <= 1'b1;
      ltssm_hold_o  <= 1'b0;
      phy_cr_sel_o  <= '0;
      dev_type_o    <= '0;
      ltssm_en_o    <= 1'b0;
      done_o        <= 1'b0;
      err_o         <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE:     if (start_i) begin core_por_n_o <= 1'b0; st_q <= S_PERST_LO; end
        S_PERST_LO: begin perst_n_o <= 1'b0;     st_q <= S_PWR_ON;   end
        S_PWR_ON:   begin slot_pwr_en_o <= 1'b1; st_q <= S_HOLD;     end
        S_HOLD:     if (dly_hit) begin perst_n_o <= 1'b1; st_q <= S_POR_REL; end
        S_POR_REL:  begin core_por_n_o <= 1'b1;  st_q <= S_AUX_ON;   end
        S_AUX_ON:   begin aux_clk_en_o <= 1'b1;  st_q <= S_LT_HOLD;  end
        S_LT_HOLD:  begin ltssm_hold_o <= 1'b1;  st_q <= S_AUX_REL;  end
        S_AUX_REL:  begin aux_rst_o <= 1'b0;     st_q <= S_SEL;      end
        S_SEL:      begin phy_cr_sel_o <= '1;    st_q <= S_SETTLE;   end
        S_SETTLE:   if (dly_hit) st_q <= S_LANE_GO;
        S_LANE_GO:  st_q <= S_LANE_WAIT;
        S_LANE_WAIT: begin
          if (wr_err) begin
            err_o <= 1'b1;
            st_q  <= S_ERR;
          end else if (wr_done) begin
            if (last_wr) st_q <= S_AUX_OFF;
            else begin idx_q <= idx_q + 1'b1; st_q <= S_LANE_GO; end
          end
        end
        S_AUX_OFF:  begin aux_clk_en_o <= 1'b0;  st_q <= S_UNHOLD;   end
        S_UNHOLD:   begin ltssm_hold_o <= 1'b0;  st_q <= S_AUX_ON2;  end
        S_AUX_ON2:  begin aux_clk_en_o <= 1'b1;  st_q <= S_DEVTYPE;  end
        S_DEVTYPE:  begin dev_type_o <= DEV_TYPE_RC; st_q <= S_LT_EN; end
        S_LT_EN:    begin ltssm_en_o <= 1'b1;    st_q <= S_DONE;     end
        S_DONE:     done_o <= 1'b1;
        default:    st_q <= S_ERR;
      endcase
    end
  end

  AST_PERST_UNDER_POR: assert property (@(posedge clk) disable iff (!rst_n)
    !perst_n_o |-> !core_por_n_o); // R3
  AST_WRITE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    phy_req_o |-> (ltssm_hold_o && aux_clk_en_o && !aux_rst_o && (&phy_cr_sel_o))); // R6
  AST_DONE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (ltssm_en_o && dev_type_o == DEV_TYPE_RC && !ltssm_hold_o && aux_clk_en_o)); // R8
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o)); // R9
  AST_FROZEN_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> (err_o && $stable({core_por_n_o, perst_n_o, slot_pwr_en_o, aux_clk_en_o,
                aux_rst_o, ltssm_hold_o, phy_cr_sel_o, phy_req_o, dev_type_o, ltssm_en_o}))); // R9
endmodule

// File: tb/pcie_rp_pwrseq_tb_top.sv
module pcie_rp_pwrseq_tb_top;
  localparam int NPHY = 2, NLANE = 4, HOLD = 6, SETTLE = 2, ACKL = 5;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, tick = 1'b0, ack = 1'b0;
  logic [31:0] dbg = '0;
  logic por_n, perst_n, pwr, auxc, auxr, hold, req, lten, lup, done, err;
  logic [NPHY-1:0] sel;
  logic [0:0] pidx;
  logic [15:0] addr, wdata;
  logic [3:0] dtype;

  always #10 clk = ~clk;

  pcie_rp_pwrseq #(.NUM_PHY(NPHY), .LANES_PER_PHY(NLANE), .HOLD_TICKS(HOLD),
                   .SETTLE_TICKS(SETTLE), .ACK_TICKS(ACKL)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .tick_i(tick), .phy_ack_i(ack),
    .link_dbg_i(dbg), .core_por_n_o(por_n), .perst_n_o(perst_n), .slot_pwr_en_o(pwr),
    .aux_clk_en_o(auxc), .aux_rst_o(auxr), .ltssm_hold_o(hold), .phy_cr_sel_o(sel),
    .phy_req_o(req), .phy_idx_o(pidx), .phy_addr_o(addr), .phy_wdata_o(wdata),
    .dev_type_o(dtype), .ltssm_en_o(lten), .link_up_o(lup), .done_o(done), .err_o(err));

  int n_run = 0, n_fail = 0, cyc = 0;
  bit mon_en = 0;
  int stall_idx = -1;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [13:0] snap();
    return {por_n, perst_n, pwr, auxc, auxr, hold, sel, dtype, lten, done};
  endfunction

  // Scoreboard queues and model of the control outputs
  logic [13:0] exp_v[$];
  int          exp_gap[$];
  string       exp_tag[$];
  logic [15:0] exp_addr[$];
  int          exp_phy[$];
  logic m_por = 1, m_perst = 1, m_pwr = 0, m_auxc = 0, m_auxr = 1, m_hold = 0, m_lt = 0, m_done = 0;
  logic [1:0] m_sel = 0;
  logic [3:0] m_dt = 0;

  task automatic push(input string tag, input int gap);
    exp_v.push_back({m_por, m_perst, m_pwr, m_auxc, m_auxr, m_hold, m_sel, m_dt, m_lt, m_done});
    exp_gap.push_back(gap);
    exp_tag.push_back(tag);
  endtask

  task automatic drive_plan();
    m_por = 0;   push("R2", 0);
    m_perst = 0; push("R2", 1);
    m_pwr = 1;   push("R2", 1);
    m_perst = 1; push("R3", 0);
    m_por = 1;   push("R3", 1);
    m_auxc = 1;  push("R4", 1);
    m_hold = 1;  push("R4", 1);
    m_auxr = 0;  push("R4", 1);
    m_sel = 2'b11; push("R4", 1);
    m_auxc = 0;  push("R8", 0);
    m_hold = 0;  push("R8", 1);
    m_auxc = 1;  push("R8", 1);
    m_dt = 4'h4; push("R8", 1);
    m_lt = 1;    push("R8", 1);
    m_done = 1;  push("R8", 1);
    for (int p = 0; p < NPHY; p++)
      for (int l = 0; l < NLANE; l++) begin
        exp_phy.push_back(p);
        exp_addr.push_back(16'h1008 + 16'(l) * 16'h0100);
      end
  endtask

  // Timebase: one tick every 4 cycles, plus window tick counters
  int tdiv = 0, hold_ticks = 0, settle_ticks = 0, reqs_seen = 0;
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 4;
    tick = (tdiv == 0);
    if (tick && pwr && !perst_n) hold_ticks++;
    if (tick && sel != 0 && reqs_seen == 0 && !req) settle_ticks++;
  end

  // PHY responder
  int req_cnt = 0, cur_idx = 0, ack_dly = 0;
  logic req_d = 0;
  always @(negedge clk) begin
    if (req && !req_d) begin cur_idx = req_cnt; req_cnt++; ack_dly = 0; end
    if (req && !ack && cur_idx != stall_idx) begin
      ack_dly++;
      if (ack_dly >= 2) ack = 1;
    end else if (!req && ack) ack = 0;
    req_d = req;
  end

  // Monitor
  logic [13:0] prev_v;
  int last_cyc = 0;
  logic mreq_d = 0, mack_d = 0;
  always @(negedge clk) begin
    cyc++;
    if (mon_en) begin
      logic [13:0] cur;
      cur = snap();
      if (cur != prev_v) begin
        if (exp_v.size() == 0) chk(0, "R2", "unexpected output change", 32'(cur), 0);
        else begin
          logic [13:0] e; int g; string t;
          e = exp_v.pop_front(); g = exp_gap.pop_front(); t = exp_tag.pop_front();
          chk(cur == e, t, "control vector", 32'(cur), 32'(e));
          if (g > 0) chk(cyc - last_cyc == g, t, "step gap", 32'(cyc - last_cyc), 32'(g));
        end
        last_cyc = cyc;
        prev_v = cur;
      end
      if (req && !mreq_d) begin
        reqs_seen++;
        chk(!mack_d, "R7", "request while ack high", 32'(mack_d), 0);
        if (exp_addr.size() == 0) chk(0, "R6", "extra lane write", 32'(addr), 0);
        else begin
          logic [15:0] ea; int ep;
          ea = exp_addr.pop_front(); ep = exp_phy.pop_front();
          chk(addr == ea, "R6", "lane address", 32'(addr), 32'(ea));
          chk(int'(pidx) == ep, "R6", "phy index", 32'(pidx), 32'(ep));
          chk(wdata == 16'hE21, "R6", "lane data", 32'(wdata), 32'hE21);
        end
      end
      if (!req && mreq_d) chk(mack_d, "R7", "request dropped before ack", 0, 1);
    end
    mreq_d = req;
    mack_d = ack;
  end

  task automatic finish_up();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  task automatic check_reset();
    chk(snap() == 14'b11_0_0_1_0_00_0000_0_0, "R1", "reset controls", 32'(snap()), 32'h3088 >> 0 == 0 ? 0 : 32'(14'b11_0_0_1_0_00_0000_0_0));
    chk(!req && !err, "R1", "reset req/err", {30'd0, req, err}, 0);
  endtask

  initial begin
    drive_plan();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_reset();
    // R10 link-up decode
    dbg = 32'h0000_0010; #2 chk(lup == 1, "R10", "up, not training", 32'(lup), 1);
    dbg = 32'h2000_0010; #2 chk(lup == 0, "R10", "up and training", 32'(lup), 0);
    dbg = 32'h0000_0000; #2 chk(lup == 0, "R10", "not up", 32'(lup), 0);
    dbg = 32'hDFFF_FFFF; #2 chk(lup == 1, "R10", "other bits set", 32'(lup), 1);
    // Run 1: complete sequence
    prev_v = snap();
    mon_en = 1;
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    for (int i = 0; i < 3000 && !done; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(done == 1, "R8", "done reached", 32'(done), 1);
    chk(exp_v.size() == 0, "R8", "steps left in queue", 32'(exp_v.size()), 0);
    chk(exp_addr.size() == 0, "R6", "writes left in queue", 32'(exp_addr.size()), 0);
    chk(hold_ticks == HOLD, "R3", "PERST hold ticks", 32'(hold_ticks), 32'(HOLD));
    chk(settle_ticks == SETTLE, "R5", "settle ticks", 32'(settle_ticks), 32'(SETTLE));
    chk(err == 0, "R9", "no error in good run", 32'(err), 0);
    // Run 2: third write never acknowledged
    mon_en = 0;
    stall_idx = 2; req_cnt = 0;
    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    check_reset();
    start = 1; @(negedge clk); start = 0;
    for (int i = 0; i < 3000 && !err; i++) @(negedge clk);
    chk(err == 1, "R9", "timeout error", 32'(err), 1);
    chk(req == 1, "R9", "request left asserted", 32'(req), 1);
    chk(req_cnt == 3, "R9", "writes attempted", 32'(req_cnt), 3);
    begin
      logic [13:0] frz;
      frz = snap();
      chk(frz == 14'b11_1_1_0_1_11_0000_0_0, "R9", "frozen controls", 32'(frz), 32'(14'b11_1_1_0_1_11_0000_0_0));
      repeat (60) @(negedge clk);
      chk(snap() == frz && err && req && !done, "R9", "stable after error", 32'(snap()), 32'(frz));
    end
    finish_up();
  end
endmodule